// File: doc/BRIEF.md
# Stop Mode Clock Recovery Controller

This block controls the low-power stop state of a small processor system. When the CPU asks to stop, the block turns off the CPU clock enable and the peripheral clock enable. If the configuration asks for it, it also turns off the two oscillator-derived clock outputs. It then waits for one of two wake events: an interrupt from a module that stays powered in stop, or a system reset.

After a wake, the block counts down a recovery delay on the reference clock. Only when that delay is over does it turn the CPU and peripheral clocks back on. It then sends a one-cycle done strobe, which tells the CPU that interrupt stacking may begin. The strobe carries a flag that says whether the wake came from a reset.

The recovery delay is either long (4096 reference cycles) or short (32 reference cycles), chosen by a fast-recovery configuration bit. A wake caused by reset always uses the long delay. A reset that arrives during an interrupt-started recovery restarts the countdown at the long value. The internal counter is held at zero for the whole stop period, so the time spent in stop never shortens the recovery.

Top module: `stop_recovery_ctrl`

## Requirements
- R1: After `rst_n` is released, `cpu_clk_en` and `per_clk_en` are 1, `osc_en` is 2'b11, and `rec_done` and `rec_from_rst` are 0.
- R2: A `stop_req` sampled while the clocks run clears `cpu_clk_en` and `per_clk_en` from the next cycle on.
- R3: During stop, `osc_en` is 2'b00 when `cfg_osc_keep` is 0 and 2'b11 when it is 1. Outside stop, `osc_en` is 2'b11.
- R4: Stop is left only through `wake_irq` or `wake_rst`. With neither asserted, the clocks stay off for as long as stop lasts. Both wake inputs have no effect while the clocks run.
- R5: The recovery counter is held at zero throughout stop, so the recovery length does not depend on how long stop lasted.
- R6: After a `wake_irq` wake, the clock enables stay low for exactly 32 cycles, counting the wake edge, when `cfg_fast` is 1, and for exactly 4096 cycles when it is 0. `cfg_fast` is sampled at the wake edge.
- R7: After a `wake_rst` wake, the clock enables stay low for exactly 4096 cycles whatever `cfg_fast` is. If `wake_irq` and `wake_rst` arrive together, the reset wins.
- R8: A `wake_rst` sampled during recovery restarts the countdown, so that the enables stay low for 4096 more cycles from that edge.
- R9: `rec_done` is high for exactly one cycle: the first cycle in which the clocks are enabled again. During that cycle `rec_from_rst` is 1 for a reset wake and 0 for an interrupt wake. At all other times it is 0.
- R10: `stop_req` has no effect during recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (crystal-derived) |
| rst_n | input | 1 | Asynchronous low-active initialisation of the block |
| stop_req | input | 1 | Stop request from the CPU |
| wake_irq | input | 1 | Interrupt from a module that stays alive in stop |
| wake_rst | input | 1 | System reset event, used as a wake source |
| cfg_fast | input | 1 | 1 selects the short recovery delay |
| cfg_osc_keep | input | 1 | 1 keeps the oscillator outputs running in stop |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 2 | Enables of the two oscillator-derived clock outputs |
| rec_done | output | 1 | One-cycle strobe: recovery done, stacking may begin |
| rec_from_rst | output | 1 | Qualifies `rec_done`: the wake came from a reset |

## Verification
The bench measures the exact length of each recovery, sample by sample. A counter loaded one value off, or a terminal test at the wrong value, would show up as 31 or 33 cycles, or 4095 or 4097 cycles. It wakes by reset with the fast bit set, and it raises both wake sources at the same time. A design that honoured the fast bit on reset, or let the interrupt win, would end recovery after 32 cycles. It injects a reset deep inside an interrupt recovery: a design that ignored it would release the clocks early, and one that did not reload would have the wrong total length. It also holds stop for a long time before waking, and it raises `stop_req` and the wake inputs in states where they must do nothing. A counter that ran during stop, or a stray state change, would show in the clock enables.

// File: rtl/stop_recovery_ctrl.sv
module stop_recovery_ctrl #(
  parameter int CNT_W      = 12,
  parameter int LONG_CYC   = 4096,
  parameter int SHORT_CYC  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wake_irq,
  input  logic       wake_rst,
  input  logic       cfg_fast,
  input  logic       cfg_osc_keep,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic [1:0] osc_en,
  output logic       rec_done,
  output logic       rec_from_rst
);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_REC} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             src_rst;
  logic             done_q;

  wire any_wake = wake_irq | wake_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_RUN;
      cnt     <= '0;
      src_rst <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_RUN: begin
          cnt <= '0;
          if (stop_req) state <= S_STOP;
        end
        S_STOP: begin
          cnt <= '0;
          if (any_wake) begin
            state   <= S_REC;
            src_rst <= wake_rst;
            cnt     <= (wake_rst || !cfg_fast) ? LONG_LD : SHORT_LD;
          end
        end
        S_REC: begin
          if (wake_rst) begin
            src_rst <= 1'b1;
            cnt     <= LONG_LD;
          end else if (cnt == '0) begin
            state  <= S_RUN;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end

  assign cpu_clk_en   = (state == S_RUN);
  assign per_clk_en   = (state == S_RUN);
  assign osc_en       = (state == S_STOP && !cfg_osc_keep) ? 2'b00 : 2'b11;
  assign rec_done     = done_q;
  assign rec_from_rst = done_q & src_rst;

  // R2
  stop_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && stop_req) |=> (!cpu_clk_en && !per_clk_en));

  // R5
  cnt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP) |-> (cnt == '0));

  // R7
  rst_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_RUN && wake_rst) |=> (cnt == LONG_LD && state == S_REC));

  // R9
  done_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_done) |-> ($past(state) == S_REC && $past(cnt) == '0 && cpu_clk_en));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !rec_done);

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && !any_wake) |=> (state == S_STOP));
endmodule

// File: tb/stop_recovery_ctrl_bench.sv
module stop_recovery_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, wake_irq = 0, wake_rst = 0, cfg_fast = 0, cfg_osc_keep = 0;
  logic cpu_clk_en, per_clk_en, rec_done, rec_from_rst;
  logic [1:0] osc_en;
  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  stop_recovery_ctrl u_stop_recovery_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_irq(wake_irq),
    .wake_rst(wake_rst), .cfg_fast(cfg_fast), .cfg_osc_keep(cfg_osc_keep),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .rec_done(rec_done), .rec_from_rst(rec_from_rst));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enter_stop();
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
  endtask

  task automatic pulse(input bit irq, input bit rs);
    @(negedge clk) begin wake_irq = irq; wake_rst = rs; end
    @(negedge clk) begin wake_irq = 0; wake_rst = 0; end
  endtask

  // count low samples from the first sample after the wake edge; check the done strobe
  task automatic measure(input string req, input int exp_len, input bit exp_rst);
    int k = 0;
    while (!cpu_clk_en && k < 10000) begin
      if (rec_done) check({req, " early done"}, 1, 0);
      k++;
      @(negedge clk);
    end
    check(req, k, exp_len);
    check("R9 done strobe", int'(rec_done), 1);
    check("R9 source flag", int'(rec_from_rst), int'(exp_rst));
    @(negedge clk);
    check("R9 one cycle", int'(rec_done), 0);
    check("R9 flag clears", int'(rec_from_rst), 0);
  endtask

  task automatic t_reset();
    check("R1 cpu en", cpu_clk_en, 1);
    check("R1 per en", per_clk_en, 1);
    check("R1 osc en", osc_en, 3);
    check("R1 done", rec_done, 0);
    check("R1 flag", rec_from_rst, 0);
  endtask

  task automatic t_wake_ignored_in_run();
    pulse(1, 0);
    pulse(0, 1);
    check("R4 run unaffected by wake", cpu_clk_en, 1);
    check("R4 no done in run", rec_done, 0);
  endtask

  task automatic t_fast_irq();
    cfg_fast = 1; cfg_osc_keep = 0;
    enter_stop();
    check("R2 cpu off", cpu_clk_en, 0);
    check("R2 per off", per_clk_en, 0);
    check("R3 osc off", osc_en, 0);
    repeat (20) @(negedge clk);
    check("R4 still stopped", cpu_clk_en, 0);
    pulse(1, 0);
    check("R3 osc on in recovery", osc_en, 3);
    measure("R6 fast irq", 32, 0);
  endtask

  task automatic t_slow_irq_long_stop();
    cfg_fast = 0; cfg_osc_keep = 1;
    enter_stop();
    check("R3 osc kept", osc_en, 3);
    repeat (6000) @(negedge clk);
    check("R4 stop holds", per_clk_en, 0);
    pulse(1, 0);
    measure("R5 R6 slow irq after long stop", 4096, 0);
  endtask

  task automatic t_rst_wake_fast();
    cfg_fast = 1; cfg_osc_keep = 0;
    enter_stop();
    pulse(0, 1);
    measure("R7 reset wake long", 4096, 1);
  endtask

  task automatic t_both_wake();
    cfg_fast = 1;
    enter_stop();
    pulse(1, 1);
    measure("R7 reset priority", 4096, 1);
  endtask

  task automatic t_rst_during_rec();
    cfg_fast = 0;
    enter_stop();
    pulse(1, 0);
    repeat (99) @(negedge clk);
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
    check("R10 stop_req ignored", cpu_clk_en, 0);
    pulse(0, 1);
    measure("R8 restart on reset", 4096, 1);
  endtask

  task automatic t_fast_stop_req_in_rec();
    cfg_fast = 1;
    enter_stop();
    pulse(1, 0);
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
    // two samples already taken in recovery
    measure("R10 fast recovery unaffected", 30, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wake_ignored_in_run();
    t_fast_irq();
    t_slow_irq_long_stop();
    t_rst_wake_fast();
    t_both_wake();
    t_rst_during_rec();
    t_fast_stop_req_in_rec();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule